// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands of `WIDTH` bits over several clocks and returns a product of `2*WIDTH` bits. A single accumulator register of double width does two jobs. Its upper half collects the running sum of partial products. Its lower half starts out holding the multiplier operand, which is consumed one bit per step as the register shifts right. A separate register holds the multiplicand, and one `WIDTH`-bit adder works only on the upper half. No dedicated multiplier register and no double-width adder are needed.

The client raises `startReq` for one cycle with both operands while the block is idle. One load cycle follows, then `WIDTH` add-and-shift steps, one per clock. When the steps are finished, `done` pulses and `resultValid` rises. The product stays on `product` until the next accepted request. Requests made while the block is busy are dropped. The width is a parameter, so a 4-bit instance can be compared exhaustively against plain arithmetic.

Top module: `shift_add_mul`

## Requirements
- R1: While `rstN` is low, and after reset until the first accepted request, `busy`, `done` and `resultValid` are 0 and `product` is all zeros.
- R2: A request is accepted when `startReq` is 1 at a rising edge while `busy` is 0. In the next cycle `busy` is 1, `resultValid` is 0, and `product` equals the multiplier operand zero-extended, so the upper `WIDTH` bits are 0.
- R3: Each busy cycle performs one step. If product bit 0 is 1, the multiplicand is added to the upper half. The full register, including the adder's carry out as the new most significant bit, is then shifted right by one. After k steps `product` equals (multiplicand × (multiplier mod 2^k)) × 2^(WIDTH−k) + floor(multiplier / 2^k).
- R4: The carry out of the upper-half add is never lost. With both operands all ones, the final product is (2^WIDTH−1)^2.
- R5: `busy` stays high for exactly `WIDTH` consecutive cycles after an accepted request.
- R6: `done` is a one-cycle pulse in the cycle after the last step. `resultValid` rises with `done` and stays high until the next accepted request, which clears it.
- R7: A `startReq` that arrives while `busy` is 1 is ignored. The running operation finishes with its original operands, and its timing does not change.
- R8: While `resultValid` is 1 and no request is accepted, `product` holds its final value.
- R9: A zero multiplicand or a zero multiplier still takes all `WIDTH` steps, with `done` seen `WIDTH`+1 cycles after the request, and the product is zero.
- R10: In a 4-bit instance, every pair of operands gives the exact product. For example, 0010 × 0011 gives 0000_0110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Request a multiply with the operands on this cycle |
| multiplicandIn | input | WIDTH | Unsigned multiplicand |
| multiplierIn | input | WIDTH | Unsigned multiplier |
| busy | output | 1 | Steps are in progress |
| done | output | 1 | One-cycle pulse when the product is complete |
| resultValid | output | 1 | Product is final; held until the next accepted request |
| product | output | 2*WIDTH | Accumulator contents; the result once `resultValid` is 1 |

## Verification
Two events can land in the same cycle: a completion (`done` pulsing while the block returns to idle) and a new request that is accepted at that very edge. There is also a request arriving on the final busy cycle, which must be dropped. The bench provokes both by holding `startReq` high across several operations while changing the operands every cycle. Requests then meet every busy cycle, including the last one, as well as the completion cycle. A behavioural model, driven from the operands captured at acceptance, predicts `busy`, `done`, `resultValid` and every intermediate value of `product`, and it judges each clock. A restart in the completion cycle must clear `resultValid` and reload the accumulator in the very next cycle.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;

  // Strobes from the control sequencer to the datapath.
  typedef struct packed {
    logic load;   // capture operands, clear upper half
    logic step;   // conditional add then right shift
  } mulCtrl_t;

  typedef enum logic {
    CTRL_IDLE = 1'b0,
    CTRL_RUN  = 1'b1
  } ctrlState_e;

endpackage

// File: rtl/mul_adder.sv
// Upper-half adder: WIDTH-bit sum plus carry out.
// USE_RIPPLE selects an explicit full-adder chain instead of the
// behavioural operator; both give the same result.
module mul_adder #(
  parameter int WIDTH      = 32,
  parameter bit USE_RIPPLE = 1'b0
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);

  generate
    if (USE_RIPPLE) begin : g_ripple
      logic [WIDTH:0] carry;
      assign carry[0] = 1'b0;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic genBit;
        logic propBit;
        assign genBit       = opA[i] & opB[i];
        assign propBit      = opA[i] ^ opB[i];
        assign sum[i]       = propBit ^ carry[i];
        assign carry[i + 1] = genBit | (propBit & carry[i]);
      end
      assign carryOut = carry[WIDTH];
    end else begin : g_behav
      logic [WIDTH:0] wideSum;
      assign wideSum  = {1'b0, opA} + {1'b0, opB};
      assign sum      = wideSum[WIDTH-1:0];
      assign carryOut = wideSum[WIDTH];
    end
  endgenerate

endmodule

// File: rtl/mul_datapath.sv
// Multiplicand register, shared accumulator/multiplier register, adder.
module mul_datapath
  import shift_add_mul_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter bit USE_RIPPLE = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  mulCtrl_t           ctrl,
  input  logic [WIDTH-1:0]   mcandIn,
  input  logic [WIDTH-1:0]   mplierIn,
  output logic [2*WIDTH-1:0] accOut
);

  localparam int ACC_W = 2 * WIDTH;

  logic [WIDTH-1:0] mcandReg;
  logic [ACC_W-1:0] accReg;
  logic [WIDTH-1:0] upperHalf;
  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] upperSum;
  logic             upperCarry;
  logic [ACC_W-1:0] accShifted;

  assign upperHalf = accReg[ACC_W-1:WIDTH];
  // Bit 0 of the accumulator is the multiplier bit under test.
  assign addend    = accReg[0] ? mcandReg : '0;

  mul_adder #(
    .WIDTH      (WIDTH),
    .USE_RIPPLE (USE_RIPPLE)
  ) adder_i (
    .opA      (upperHalf),
    .opB      (addend),
    .sum      (upperSum),
    .carryOut (upperCarry)
  );

  // Carry becomes the new MSB; the tested bit drops off the bottom.
  assign accShifted = {upperCarry, upperSum, accReg[WIDTH-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcandReg <= '0;
      accReg   <= '0;
    end else if (ctrl.load) begin
      mcandReg <= mcandIn;
      accReg   <= {{WIDTH{1'b0}}, mplierIn};
    end else if (ctrl.step) begin
      accReg   <= accShifted;
    end
  end

  assign accOut = accReg;

endmodule

// File: rtl/mul_ctrl.sv
// Sequencer: accepts a request when idle, runs WIDTH steps, flags completion.
module mul_ctrl
  import shift_add_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  output mulCtrl_t ctrl,
  output logic     busy,
  output logic     done,
  output logic     resultValid
);

  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] STEP_COUNT = CNT_W'(WIDTH);
  localparam logic [CNT_W-1:0] LAST_STEP  = CNT_W'(1);

  ctrlState_e       state;
  logic [CNT_W-1:0] stepsLeft;
  logic             acceptReq;

  assign acceptReq = (state == CTRL_IDLE) && startReq;

  always_comb begin
    ctrl      = '0;
    ctrl.load = acceptReq;
    ctrl.step = (state == CTRL_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= CTRL_IDLE;
      stepsLeft   <= '0;
      done        <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        CTRL_IDLE: begin
          if (acceptReq) begin
            state       <= CTRL_RUN;
            stepsLeft   <= STEP_COUNT;
            resultValid <= 1'b0;
          end
        end
        CTRL_RUN: begin
          stepsLeft <= stepsLeft - 1'b1;
          if (stepsLeft == LAST_STEP) begin
            state       <= CTRL_IDLE;
            done        <= 1'b1;
            resultValid <= 1'b1;
          end
        end
        default: state <= CTRL_IDLE;
      endcase
    end
  end

  assign busy = (state == CTRL_RUN);

endmodule

// File: rtl/shift_add_mul.sv
// Thin top: sequencer plus datapath.
module shift_add_mul
  import shift_add_mul_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter bit USE_RIPPLE = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [WIDTH-1:0]   multiplicandIn,
  input  logic [WIDTH-1:0]   multiplierIn,
  output logic               busy,
  output logic               done,
  output logic               resultValid,
  output logic [2*WIDTH-1:0] product
);

  mulCtrl_t ctrlStrobes;

  mul_ctrl #(
    .WIDTH (WIDTH)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .ctrl        (ctrlStrobes),
    .busy        (busy),
    .done        (done),
    .resultValid (resultValid)
  );

  mul_datapath #(
    .WIDTH      (WIDTH),
    .USE_RIPPLE (USE_RIPPLE)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrlStrobes),
    .mcandIn  (multiplicandIn),
    .mplierIn (multiplierIn),
    .accOut   (product)
  );

endmodule

// File: rtl/shift_add_mul_chk.sv
module shift_add_mul_chk #(
  parameter int WIDTH = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               startReq,
  input logic [WIDTH-1:0]   multiplierIn,
  input logic               busy,
  input logic               done,
  input logic               resultValid,
  input logic [2*WIDTH-1:0] product
);

  localparam int RUN_W = $clog2(WIDTH + 2);

  // Length of the current busy run, counted in the checker.
  logic [RUN_W-1:0] runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runLen <= '0;
    else if (busy) runLen <= runLen + 1'b1;
    else           runLen <= '0;
  end

  // R2
  load_contents_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> (busy && !resultValid &&
      product == {{WIDTH{1'b0}}, $past(multiplierIn)}));

  // R5
  busy_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (runLen < RUN_W'(WIDTH)));

  // R5
  done_after_full_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (runLen == RUN_W'(WIDTH)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  done_sets_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (resultValid && !busy));

  // R6
  valid_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !startReq) |=> resultValid);

  // R8
  result_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !startReq) |=> $stable(product));

  // R7
  ignore_busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && runLen < RUN_W'(WIDTH - 1)) |=> busy);

endmodule

bind shift_add_mul shift_add_mul_chk #(.WIDTH(WIDTH)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .startReq     (startReq),
  .multiplierIn (multiplierIn),
  .busy         (busy),
  .done         (done),
  .resultValid  (resultValid),
  .product      (product)
);

// File: tb/shift_add_mul_tb_top.sv
`timescale 1ns/1ps

// Behavioural reference: predicts every output each clock from captured operands.
module mul_scoreboard #(
  parameter int W = 4
) (
  input logic           clk,
  input logic           rstN,
  input logic           startReq,
  input logic [W-1:0]   aIn,
  input logic [W-1:0]   bIn,
  input logic           busy,
  input logic           done,
  input logic           resultValid,
  input logic [2*W-1:0] product
);
  int checks = 0;
  int fails  = 0;
  int remaining = 0;
  int stepsDone = 0;
  bit expValid = 0, expDone = 0, seenEdge = 0, justLoaded = 0, ran = 0;
  logic [W-1:0] capA = '0, capB = '0;

  function automatic logic [2*W-1:0] partialProd(logic [W-1:0] a, logic [W-1:0] b, int k);
    logic [2*W-1:0] wa, wb, mask;
    wa   = {{W{1'b0}}, a};
    wb   = {{W{1'b0}}, b};
    mask = ({{(2*W-1){1'b0}}, 1'b1} << k) - 1'b1;
    return ((wa * (wb & mask)) << (W - k)) | (wb >> k);
  endfunction

  task automatic cmp(string tag, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s W=%0d t=%0t actual=%h expected=%h", tag, W, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    seenEdge   = 1;
    expDone    = 0;
    justLoaded = 0;
    if (!rstN) begin
      remaining = 0; stepsDone = 0; expValid = 0; ran = 0;
    end else if (remaining > 0) begin
      remaining--; stepsDone++;
      if (remaining == 0) begin expDone = 1; expValid = 1; end
    end else if (startReq) begin
      remaining = W; stepsDone = 0; expValid = 0;
      capA = aIn; capB = bIn; ran = 1; justLoaded = 1;
    end
  end

  always @(negedge clk) begin
    if (seenEdge) begin
      logic [2*W-1:0] expP;
      string tag;
      expP = ran ? partialProd(capA, capB, stepsDone) : '0;
      if (!rstN || !ran)    tag = "R1 product";
      else if (justLoaded)  tag = "R2 product";
      else if (remaining>0) tag = "R3 product";
      else                  tag = "R8 product";
      cmp("R5 busy", {{(2*W-1){1'b0}}, busy}, {{(2*W-1){1'b0}}, remaining > 0});
      cmp("R6 done", {{(2*W-1){1'b0}}, done}, {{(2*W-1){1'b0}}, expDone});
      cmp("R6 resultValid", {{(2*W-1){1'b0}}, resultValid}, {{(2*W-1){1'b0}}, expValid});
      cmp(tag, product, expP);
    end
  end
endmodule

module shift_add_mul_tb_top;
  logic clk = 0;
  logic rstN = 0;
  always #4 clk = ~clk;   // 125 MHz

  logic        st32 = 0, busy32, done32, valid32;
  logic [31:0] a32 = '0, b32 = '0;
  logic [63:0] prod32;
  logic        st4 = 0, busy4, done4, valid4;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [7:0]  prod4;

  int tbChecks = 0, tbFails = 0, cycleCount = 0;

  shift_add_mul #(.WIDTH(32)) dut_i (
    .clk(clk), .rstN(rstN), .startReq(st32), .multiplicandIn(a32), .multiplierIn(b32),
    .busy(busy32), .done(done32), .resultValid(valid32), .product(prod32));

  shift_add_mul #(.WIDTH(4), .USE_RIPPLE(1'b1)) dut4_i (
    .clk(clk), .rstN(rstN), .startReq(st4), .multiplicandIn(a4), .multiplierIn(b4),
    .busy(busy4), .done(done4), .resultValid(valid4), .product(prod4));

  mul_scoreboard #(.W(32)) sb32_i (
    .clk(clk), .rstN(rstN), .startReq(st32), .aIn(a32), .bIn(b32),
    .busy(busy32), .done(done32), .resultValid(valid32), .product(prod32));

  mul_scoreboard #(.W(4)) sb4_i (
    .clk(clk), .rstN(rstN), .startReq(st4), .aIn(a4), .bIn(b4),
    .busy(busy4), .done(done4), .resultValid(valid4), .product(prod4));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    tbChecks++;
    if (act !== exp) begin
      tbFails++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d",
             tbChecks + sb32_i.checks + sb4_i.checks,
             tbFails + sb32_i.fails + sb4_i.fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 150000) begin
      tbChecks++; tbFails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycleCount);
      summary();
    end
  end

  // Issue one request on the 32-bit unit; return cycles until done seen.
  task automatic run32(input logic [31:0] a, input logic [31:0] b, output int lat);
    @(negedge clk); st32 = 1; a32 = a; b32 = b;
    @(negedge clk); st32 = 0; lat = 1;
    while (!done32 && lat < 200) begin @(negedge clk); lat++; end
  endtask

  task automatic run4(input logic [3:0] a, input logic [3:0] b);
    int guard;
    @(negedge clk); st4 = 1; a4 = a; b4 = b;
    @(negedge clk); st4 = 0; guard = 0;
    while (!done4 && guard < 50) begin @(negedge clk); guard++; end
  endtask

  initial begin
    int lat;
    logic [63:0] firstExp;
    rstN = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", {63'd0, busy32}, 64'd0);
    check("R1 product", prod32, 64'd0);
    rstN = 1;
    repeat (2) @(negedge clk);
    check("R1 idle valid", {63'd0, valid32}, 64'd0);

    run32(32'd3, 32'd5, lat);
    check("R6 basic product", prod32, 64'd15);
    check("R5 latency", 64'(lat), 64'd33);

    // R9: zero operands still run every step
    run32(32'd0, 32'hDEAD_BEEF, lat);
    check("R9 zero multiplicand", prod32, 64'd0);
    check("R9 zero multiplicand latency", 64'(lat), 64'd33);
    run32(32'h1234_5678, 32'd0, lat);
    check("R9 zero multiplier", prod32, 64'd0);
    check("R9 zero multiplier latency", 64'(lat), 64'd33);

    // R4: carry out must reach the MSB
    run32(32'hFFFF_FFFF, 32'hFFFF_FFFF, lat);
    check("R4 all ones", prod32, 64'hFFFF_FFFE_0000_0001);
    run32(32'h8000_0000, 32'h8000_0001, lat);
    check("R4 high bits", prod32, 64'h4000_0000_8000_0000);

    // R8: result holds while idle
    repeat (10) @(negedge clk);
    check("R8 hold", prod32, 64'h4000_0000_8000_0000);

    // R7: requests while busy are dropped
    firstExp = 64'(32'h0001_0003) * 64'(32'h0000_F00D);
    @(negedge clk); st32 = 1; a32 = 32'h0001_0003; b32 = 32'h0000_F00D;
    @(negedge clk); st32 = 0;
    repeat (5) @(negedge clk);
    st32 = 1; a32 = 32'hFFFF_0000; b32 = 32'h7;
    repeat (3) @(negedge clk);
    st32 = 0; lat = 0;
    while (!done32 && lat < 200) begin @(negedge clk); lat++; end
    check("R7 ignored request", prod32, firstExp);

    // R6/R7: held request collides with last step and with completion
    @(negedge clk); st32 = 1;
    for (int i = 0; i < 110; i++) begin
      a32 = 32'h9E37_79B9 * (i + 1); b32 = 32'h85EB_CA6B ^ (i * 32'h0101_0101);
      @(negedge clk);
    end
    st32 = 0;
    repeat (40) @(negedge clk);

    // R10: exhaustive 4-bit, including the 0010 x 0011 example
    run4(4'b0010, 4'b0011);
    check("R10 example", {56'd0, prod4}, 64'h06);
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        run4(4'(a), 4'(b));
        check("R10 exhaustive", {56'd0, prod4}, 64'(a * b));
      end
    end

    // R1: reset mid-operation clears everything
    @(negedge clk); st32 = 1; a32 = 32'd7; b32 = 32'd9;
    @(negedge clk); st32 = 0;
    repeat (4) @(negedge clk);
    rstN = 0;
    @(negedge clk);
    check("R1 reset during run", {prod32[62:0], busy32}, 64'd0);
    rstN = 1;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule